// File: doc/BRIEF.md
# Timed Operation Abort Counter

This block lets software cut a flash operation short after a chosen number of clock cycles. Software writes a countdown value and then arms the block. The next command strobe from the flash controller starts the countdown. When the count runs out, the block raises a one-cycle abort request. The controller's sequencer uses that request to jump into its RESET command sequence. The strobe carries no opcode, so every command can be cut short in the same way and no new opcodes are needed. The block does not build the RESET bytes and does not alter the controller's sequencer. The busy-interval timer is a separate block and keeps running while an abort takes place.

A four-state machine sequences the block. The states are IDLE, ARMED, COUNT and FIRE, and the transitions between them are:
- IDLE→ARMED on an arm write.
- ARMED→COUNT on a command strobe. The countdown register takes the programmed value on this edge.
- ARMED→IDLE and COUNT→IDLE on a cancel write.
- COUNT→FIRE when the count is zero and no cancel is written.
- FIRE→IDLE unconditionally. The abort request is high for the single cycle spent in FIRE.

A sticky flag records that an abort fired and stays set until software clears it.

Top module: `op_abort_timer`

## Requirements
- R1: After reset the abort request is 0, the state is IDLE, the status word reads 0, the programmed value reads 0 and the remaining count reads 0.
- R2: The register port is decoded by address. Address 0 holds the programmed countdown value and can be read and written. Address 1 takes write-1 commands: bit 0 arms, bit 1 cancels, bit 2 clears the abort flag. Reading address 1 returns status: bit 0 armed (ARMED or COUNT), bit 1 counting (COUNT), bit 2 abort flag. Address 2 returns the remaining count and ignores writes. Address 3 reads 0. Read data is combinational from the address.
- R3: A command strobe in IDLE is ignored. In ARMED, a strobe moves the block to COUNT and loads the programmed value into the countdown register.
- R4: In COUNT the count falls by one every cycle. On the edge where the count is already 0, the block enters FIRE. For a programmed value N, the abort request is high for exactly one cycle, starting N+1 rising edges after the edge that samples the strobe.
- R5: Command strobes during COUNT or FIRE neither restart nor reload the countdown.
- R6: When the block leaves FIRE it returns to IDLE with armed cleared. The abort flag rises on the same edge as the abort request and stays set until a clear write. If a clear write arrives on the edge where the flag is set, the set wins.
- R7: A cancel write in ARMED or COUNT returns the block to IDLE with no abort request. The remaining count freezes at its value after that edge. A cancel on the edge where the count would expire wins over the expiry. If arm and cancel are written together, the cancel wins.
- R8: An arm write in ARMED, COUNT or FIRE has no effect on the running countdown.
- R9: Writing the programmed value during COUNT does not change the running count. The new value is used at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational from address) |
| cmd_issued_i | input | 1 | One-cycle strobe: controller issued a command |
| abort_req_o | output | 1 | One-cycle request to jump to the RESET sequence |

## Verification
Two of the block's functions can fall on the same edge, and the bench aims a write at each of these edges.

The first collision is between a software cancel and the expiry of the countdown. A cancel write is placed on the exact edge where the count is already zero and FIRE would be entered. The bench expects no abort request, an IDLE status and a clear flag.

The second collision is between a flag-clear write and the setting of the flag. The clear is placed on the edge that enters FIRE. The bench expects the pulse and a flag still set afterwards.

Both edges are found by counting rising edges from the sampled strobe, using the programmed value.

// File: rtl/abort_pkg.sv
package abort_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2,
        ST_FIRE  = 2'd3
    } abort_state_e;

    // register addresses
    localparam int ADDR_LOAD  = 0;
    localparam int ADDR_CTRL  = 1;
    localparam int ADDR_COUNT = 2;

    // control write bits (write-1 commands)
    localparam int CTRL_ARM    = 0;
    localparam int CTRL_CANCEL = 1;
    localparam int CTRL_CLEAR  = 2;

    // status read bits
    localparam int STAT_ARMED    = 0;
    localparam int STAT_COUNTING = 1;
    localparam int STAT_ABORTED  = 2;

endpackage

// File: rtl/abort_counter.sv
module abort_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    output logic [CNT_W-1:0] count_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= load_val_i;
        end else if (run_i && (count_q != '0)) begin
            count_q <= count_q - CNT_W'(1);
        end
    end

    assign count_o = count_q;
    assign zero_o  = (count_q == '0);

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !load_i && !zero_o) |=> (count_q == $past(count_q) - CNT_W'(1)));

endmodule

// File: rtl/abort_fsm.sv
module abort_fsm
    import abort_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm_req_i,
    input  logic         cancel_req_i,
    input  logic         cmd_i,
    input  logic         cnt_zero_i,
    output logic         start_o,
    output logic         run_o,
    output logic         fire_set_o,
    output logic         armed_o,
    output logic         counting_o,
    output logic         abort_o
);

    abort_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (arm_req_i && !cancel_req_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (cancel_req_i)  state_d = ST_IDLE;
                else if (cmd_i)    state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (cancel_req_i)    state_d = ST_IDLE;
                else if (cnt_zero_i) state_d = ST_FIRE;
            end
            ST_FIRE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        start_o    = 1'b0;
        run_o      = 1'b0;
        fire_set_o = 1'b0;
        armed_o    = 1'b0;
        counting_o = 1'b0;
        abort_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARMED: begin
                armed_o = 1'b1;
                start_o = cmd_i && !cancel_req_i;
            end
            ST_COUNT: begin
                armed_o    = 1'b1;
                counting_o = 1'b1;
                run_o      = 1'b1;
                fire_set_o = cnt_zero_i && !cancel_req_i;
            end
            ST_FIRE: begin
                abort_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R4
    abort_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o);

    // R7
    cancel_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_req_i && (state_q == ST_ARMED || state_q == ST_COUNT))
        |=> (state_q == ST_IDLE && !abort_o));

    // R3
    idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_COUNT && !abort_o));

endmodule

// File: rtl/abort_regs.sv
module abort_regs
    import abort_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              fire_set_i,
    input  logic              armed_i,
    input  logic              counting_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CNT_W-1:0]  load_val_o,
    output logic              arm_req_o,
    output logic              cancel_req_o,
    output logic              aborted_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic              wr_load, wr_ctrl, clr_req;
    logic [CNT_W-1:0]  load_q;
    logic              aborted_q;
    logic [DATA_W-1:0] load_ext, count_ext;

    assign wr_load      = wr_i && (addr_i == ADDR_W'(ADDR_LOAD));
    assign wr_ctrl      = wr_i && (addr_i == ADDR_W'(ADDR_CTRL));
    assign arm_req_o    = wr_ctrl && wdata_i[CTRL_ARM];
    assign cancel_req_o = wr_ctrl && wdata_i[CTRL_CANCEL];
    assign clr_req      = wr_ctrl && wdata_i[CTRL_CLEAR];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
        end else if (wr_load) begin
            load_q <= wdata_i[CNT_W-1:0];
        end
    end

    // set has priority over a clear on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aborted_q <= 1'b0;
        end else if (fire_set_i) begin
            aborted_q <= 1'b1;
        end else if (clr_req) begin
            aborted_q <= 1'b0;
        end
    end

    generate
        if (DATA_W > CNT_W) begin : g_pad
            assign load_ext  = {{(DATA_W-CNT_W){1'b0}}, load_q};
            assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count_i};
        end else begin : g_exact
            assign load_ext  = load_q;
            assign count_ext = count_i;
        end
    endgenerate

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(ADDR_LOAD)) begin
            rdata_o = load_ext;
        end else if (addr_i == ADDR_W'(ADDR_CTRL)) begin
            rdata_o[STAT_ARMED]    = armed_i;
            rdata_o[STAT_COUNTING] = counting_i;
            rdata_o[STAT_ABORTED]  = aborted_q;
        end else if (addr_i == ADDR_W'(ADDR_COUNT)) begin
            rdata_o = count_ext;
        end
    end

    assign load_val_o = load_q;
    assign aborted_o  = aborted_q;

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_set_i |=> aborted_q);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (aborted_q && !clr_req) |=> aborted_q);

endmodule

// File: rtl/op_abort_timer.sv
module op_abort_timer #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic              cmd_issued_i,
    output logic              abort_req_o
);

    logic [CNT_W-1:0] load_val, count;
    logic arm_req, cancel_req, aborted;
    logic start, run, fire_set, armed, counting, cnt_zero;

    abort_regs #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (reg_wr_i),
        .addr_i       (reg_addr_i),
        .wdata_i      (reg_wdata_i),
        .fire_set_i   (fire_set),
        .armed_i      (armed),
        .counting_i   (counting),
        .count_i      (count),
        .load_val_o   (load_val),
        .arm_req_o    (arm_req),
        .cancel_req_o (cancel_req),
        .aborted_o    (aborted),
        .rdata_o      (reg_rdata_o)
    );

    abort_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .arm_req_i    (arm_req),
        .cancel_req_i (cancel_req),
        .cmd_i        (cmd_issued_i),
        .cnt_zero_i   (cnt_zero),
        .start_o      (start),
        .run_o        (run),
        .fire_set_o   (fire_set),
        .armed_o      (armed),
        .counting_o   (counting),
        .abort_o      (abort_req_o)
    );

    abort_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (start),
        .load_val_i (load_val),
        .run_i      (run),
        .count_o    (count),
        .zero_o     (cnt_zero)
    );

    // R4
    fire_after_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req_o |-> $past(cnt_zero));

    // R6
    disarm_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req_o |-> (!armed && aborted));

    // R9
    load_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !cnt_zero && !start) |=> (count != load_val || $past(count) == load_val + CNT_W'(1)));

endmodule

// File: tb/tb_op_abort_timer.sv
module tb_op_abort_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd1;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd = 1'b0;
    logic        abort;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    op_abort_timer dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr_i     (reg_wr),
        .reg_addr_i   (reg_addr),
        .reg_wdata_i  (reg_wdata),
        .reg_rdata_o  (reg_rdata),
        .cmd_issued_i (cmd),
        .abort_req_o  (abort)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 2'd1;
    endtask

    // strobe at n0, returns the negedge index where abort is seen
    task automatic run_cmd(input int strike_at, input int arm_at, input int load_at,
                           input logic [31:0] load_data, output int cyc);
        @(negedge clk);
        cmd = 1'b1;
        cyc = 0;
        for (int k = 1; k <= 100; k++) begin
            @(negedge clk);
            cmd = 1'b0; reg_wr = 1'b0; reg_addr = 2'd1;
            cyc = k;
            if (abort) break;
            if (k == strike_at) cmd = 1'b1;
            if (k == arm_at) begin
                reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1;
            end else if (k == load_at) begin
                reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = load_data;
            end
        end
        @(negedge clk);
        chk("R4 pulse lasts one cycle", {31'd0, abort}, 32'd0);
    endtask

    task automatic watch_quiet(input string tag, input int n);
        logic seen;
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (abort) seen = 1'b1;
        end
        chk(tag, {31'd0, seen}, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 abort after reset", {31'd0, abort}, 32'd0);
        rd(2'd1, d); chk("R1 status after reset", d, 32'd0);
        rd(2'd0, d); chk("R1 load after reset", d, 32'd0);
        rd(2'd2, d); chk("R1 count after reset", d, 32'd0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        wr(2'd0, 32'h1234_5678);
        rd(2'd0, d); chk("R2 load readback", d, 32'h1234_5678);
        wr(2'd2, 32'hFF);
        rd(2'd2, d); chk("R2 count read-only", d, 32'd0);
        rd(2'd3, d); chk("R2 unused address", d, 32'd0);
    endtask

    task automatic t_idle_strobe;
        logic [31:0] d;
        @(negedge clk); cmd = 1'b1;
        @(negedge clk); cmd = 1'b0;
        watch_quiet("R3 strobe in IDLE no abort", 10);
        rd(2'd1, d); chk("R3 status stays IDLE", d, 32'd0);
        rd(2'd2, d); chk("R3 count not loaded", d, 32'd0);
    endtask

    task automatic t_basic;
        logic [31:0] d;
        int cyc;
        wr(2'd0, 32'd5);
        wr(2'd1, 32'h1);
        rd(2'd1, d); chk("R3 armed status", d, 32'h1);
        run_cmd(0, 0, 0, 0, cyc);
        chk("R4 abort timing N=5", cyc, 32'd7);
        rd(2'd1, d); chk("R6 status after fire", d, 32'h4);
        rd(2'd2, d); chk("R4 count at zero", d, 32'd0);
    endtask

    task automatic t_zero;
        logic [31:0] d;
        int cyc;
        wr(2'd1, 32'h4);
        rd(2'd1, d); chk("R6 flag cleared", d, 32'd0);
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h1);
        run_cmd(0, 0, 0, 0, cyc);
        chk("R4 abort timing N=0", cyc, 32'd2);
    endtask

    task automatic t_restrike;
        int cyc;
        wr(2'd0, 32'd6);
        wr(2'd1, 32'h1);
        run_cmd(3, 0, 0, 0, cyc);
        chk("R5 restrike ignored", cyc, 32'd8);
    endtask

    task automatic t_set_vs_clear;
        logic [31:0] d;
        wr(2'd1, 32'h4);
        wr(2'd0, 32'd2);
        wr(2'd1, 32'h1);
        @(negedge clk); cmd = 1'b1;          // n0
        @(negedge clk); cmd = 1'b0;          // n1
        @(negedge clk);                      // n2
        @(negedge clk);                      // n3: clear sampled at fire edge
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h4;
        @(negedge clk);                      // n4
        reg_wr = 1'b0; reg_addr = 2'd1;
        chk("R4 abort at fire edge", {31'd0, abort}, 32'd1);
        #1 chk("R6 set wins over clear", reg_rdata, 32'h4);
        wr(2'd1, 32'h4);
        rd(2'd1, d); chk("R6 later clear works", d, 32'd0);
    endtask

    task automatic t_cancel;
        logic [31:0] d;
        wr(2'd0, 32'd3);
        wr(2'd1, 32'h1);
        wr(2'd1, 32'h2);
        rd(2'd1, d); chk("R7 cancel in ARMED", d, 32'd0);
        @(negedge clk); cmd = 1'b1;
        @(negedge clk); cmd = 1'b0;
        watch_quiet("R7 no abort after ARMED cancel", 8);
        wr(2'd0, 32'd10);
        wr(2'd1, 32'h1);
        @(negedge clk); cmd = 1'b1;          // n0
        @(negedge clk); cmd = 1'b0;          // n1
        @(negedge clk);                      // n2
        @(negedge clk);                      // n3
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h2;
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk("R7 cancel in COUNT status", reg_rdata, 32'd0);
        rd(2'd2, d); chk("R7 count frozen", d, 32'd7);
        watch_quiet("R7 no abort after COUNT cancel", 15);
    endtask

    task automatic t_race;
        logic [31:0] d;
        wr(2'd0, 32'd3);
        wr(2'd1, 32'h1);
        @(negedge clk); cmd = 1'b1;          // n0
        @(negedge clk); cmd = 1'b0;          // n1
        @(negedge clk);                      // n2
        @(negedge clk);                      // n3
        @(negedge clk);                      // n4: cancel sampled at expiry edge
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h2;
        @(negedge clk);                      // n5
        reg_wr = 1'b0;
        chk("R7 cancel beats expiry", {31'd0, abort}, 32'd0);
        #1 chk("R7 status after race", reg_rdata, 32'd0);
        watch_quiet("R7 quiet after race", 5);
        rd(2'd1, d); chk("R7 flag not set", d, 32'd0);
    endtask

    task automatic t_rearm;
        int cyc;
        wr(2'd0, 32'd4);
        wr(2'd1, 32'h1);
        run_cmd(0, 2, 0, 0, cyc);
        chk("R8 arm during count ignored", cyc, 32'd6);
        wr(2'd1, 32'h4);
    endtask

    task automatic t_load_change;
        logic [31:0] d;
        int cyc;
        wr(2'd0, 32'd5);
        wr(2'd1, 32'h1);
        run_cmd(0, 0, 2, 32'd20, cyc);
        chk("R9 running count unchanged", cyc, 32'd7);
        rd(2'd0, d); chk("R9 new load stored", d, 32'd20);
        wr(2'd1, 32'h5);
        run_cmd(0, 0, 0, 0, cyc);
        chk("R9 new load used next start", cyc, 32'd22);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_idle_strobe();
        t_basic();
        t_zero();
        t_restrike();
        t_set_vs_clear();
        t_cancel();
        t_race();
        t_rearm();
        t_load_change();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule